// File: doc/BRIEF.md
# Jitter FIFO Pointer-Interval Monitor

This block is the elastic bit store of one link's jitter attenuator. A write strobe pushes one line bit into a FIFO and a read strobe pops one bit out. Both strobes are enables in a single clock domain. The block reports the fill level, which is the distance between the write and read pointers, on a 7-bit status output. That output either follows the level every cycle or holds the largest level seen. When the level comes close to empty or full, the block raises a request that tells the rate-control logic to widen its tracking bandwidth, but only if widened mode is selected.

The usable depth is chosen at run time with a 2-bit select. Changing the select, holding the attenuator disabled, and reset all place the pointers half a depth apart with the storage cleared to zeros. While the attenuator is disabled, input bits go straight to the output and the FIFO is not touched. A write into a full store or a read from an empty one is refused, and the refusal sets a sticky error flag.

Top module: `jitter_fifo_mon`

## Requirements
- R1: Depth select 00 gives 128 bits, 01 gives 64, and 10 or 11 give 32. A change of the select restarts the FIFO, and the level is then half the new depth from the next cycle.
- R2: With the attenuator enabled and the FIFO not empty, `rd_bit` shows the oldest stored bit. Bits leave in the order they were written. Bits preloaded by a restart read as 0.
- R3: With `peak_mode` = 0, `occ` equals the fill level after every clock edge.
- R4: With `peak_mode` = 1 and no clear, `occ` only rises: it takes the new level when that level is larger and otherwise keeps its value.
- R5: A fill level of 128 is reported on `occ` as 127.
- R6: A one-cycle `peak_clr` loads `occ` with the current level, even in peak mode.
- R7: The near-limit window is 2 bits for depth 32, 3 bits for depth 64 and 4 bits for depth 128. `widen_req` is 1 exactly when `widen_mode` and `att_en` are 1 and the level is within the window of 0 or of the depth.
- R8: With `att_en` = 0, `rd_bit` equals `wr_bit` in the same cycle, and the FIFO is held at its restart state.
- R9: A write to a full FIFO without a simultaneous read, or a read from an empty FIFO, is refused without changing the pointers and sets `err`, which stays set until reset.
- R10: After reset the depth is 128, the level and `occ` are 64, and `err` and `widen_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write-side bit strobe |
| wr_bit | input | 1 | Bit to store |
| rd_en | input | 1 | Read-side bit strobe |
| rd_bit | output | 1 | Oldest stored bit, or `wr_bit` in bypass |
| depth_sel | input | 2 | Depth select: 00=128, 01=64, 1x=32 |
| att_en | input | 1 | 1 = use the FIFO, 0 = bypass |
| peak_mode | input | 1 | 0 = live level on `occ`, 1 = peak hold |
| peak_clr | input | 1 | Load the peak hold with the current level |
| widen_mode | input | 1 | Allow the widen request |
| occ | output | 7 | Fill level status, saturated at 127 |
| widen_req | output | 1 | Level is inside the near-limit window |
| err | output | 1 | Sticky overflow or underflow flag |

## Verification
A wrong level or a wrong pointer shows up at the ports within one cycle. The status output departs from the expected fill level, or `rd_bit` presents a bit out of order at the next read. A stale depth after a select change shows as a wrong restart level on the very next cycle and as a widen request in the wrong window. A lost refusal on a full or empty store shows as `err` staying low after that cycle, and as data read out of order afterwards.

// File: rtl/jfm_pkg.sv
package jfm_pkg;

    typedef enum logic [1:0] {
        DSEL_FULL    = 2'b00,
        DSEL_HALF    = 2'b01,
        DSEL_QUART_A = 2'b10,
        DSEL_QUART_B = 2'b11
    } depth_sel_e;

    // Clamp a fill level to the all-ones value of a narrower status field.
    function automatic logic [7:0] clip_level(input logic [7:0] lvl, input logic [7:0] top);
        return (lvl > top) ? top : lvl;
    endfunction

endpackage

// File: rtl/jfm_depth_dec.sv
module jfm_depth_dec #(
    parameter int MAX_DEPTH = 128,
    parameter int WIN_MAX   = 4,
    localparam int PW = $clog2(MAX_DEPTH),
    localparam int CW = PW + 1
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] depth,
    output logic [CW-1:0] half,
    output logic [CW-1:0] win,
    output logic [PW-1:0] mask
);
    import jfm_pkg::*;

    always_comb begin
        unique case (depth_sel_e'(sel))
            DSEL_FULL: begin
                depth = CW'(MAX_DEPTH);
                win   = CW'(WIN_MAX);
            end
            DSEL_HALF: begin
                depth = CW'(MAX_DEPTH / 2);
                win   = CW'(WIN_MAX - 1);
            end
            default: begin
                depth = CW'(MAX_DEPTH / 4);
                win   = CW'(WIN_MAX - 2);
            end
        endcase
        half = depth >> 1;
        mask = PW'(depth - CW'(1));
    end

endmodule

// File: rtl/jfm_store.sv
module jfm_store #(
    parameter int MAX_DEPTH = 128,
    localparam int PW = $clog2(MAX_DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [1:0]    sel,
    input  logic [CW-1:0] depth,
    input  logic [CW-1:0] half,
    input  logic [PW-1:0] mask,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          rd_en,
    output logic          head_bit,
    output logic [CW-1:0] lvl_q,
    output logic [CW-1:0] lvl_d,
    output logic [1:0]    dsel_q,
    output logic          err_q
);
    typedef struct packed {
        logic [MAX_DEPTH-1:0] mem;
        logic [PW-1:0]        wp;
        logic [PW-1:0]        rp;
        logic [CW-1:0]        lvl;
        logic [1:0]           dsel;
        logic                 err;
    } store_t;

    store_t st_q, st_d;
    logic   rd_ok, wr_ok;

    always_comb begin
        st_d  = st_q;
        rd_ok = rd_en && (st_q.lvl != '0);
        wr_ok = wr_en && ((st_q.lvl != depth) || rd_ok);
        if (restart) begin
            st_d.mem  = '0;
            st_d.wp   = PW'(half);
            st_d.rp   = '0;
            st_d.lvl  = half;
            st_d.dsel = sel;
        end else begin
            if (rd_ok) begin
                st_d.rp = (st_q.rp + PW'(1)) & mask;
            end
            if (wr_ok) begin
                st_d.mem[st_q.wp] = wr_bit;
                st_d.wp = (st_q.wp + PW'(1)) & mask;
            end
            st_d.lvl = st_q.lvl + CW'(wr_ok) - CW'(rd_ok);
            if ((wr_en && !wr_ok) || (rd_en && !rd_ok)) begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mem  <= '0;
            st_q.wp   <= PW'(MAX_DEPTH / 2);
            st_q.rp   <= '0;
            st_q.lvl  <= CW'(MAX_DEPTH / 2);
            st_q.dsel <= 2'b00;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_bit = st_q.mem[st_q.rp];
    assign lvl_q    = st_q.lvl;
    assign lvl_d    = st_d.lvl;
    assign dsel_q   = st_q.dsel;
    assign err_q    = st_q.err;

endmodule

// File: rtl/jfm_status.sv
module jfm_status #(
    parameter int CW     = 8,
    parameter int SW     = 7,
    parameter int RST_LV = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          peak_mode,
    input  logic          peak_clr,
    input  logic [CW-1:0] lvl_d,
    output logic [SW-1:0] occ_q
);
    import jfm_pkg::*;

    localparam logic [7:0] TOP = 8'((1 << SW) - 1);

    logic [SW-1:0] occ_d;
    logic [SW-1:0] cur;

    always_comb begin
        cur = SW'(clip_level(8'(lvl_d), TOP));
        if (restart || !peak_mode || peak_clr) begin
            occ_d = cur;
        end else begin
            occ_d = (cur > occ_q) ? cur : occ_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= SW'(RST_LV);
        end else begin
            occ_q <= occ_d;
        end
    end

endmodule

// File: rtl/jitter_fifo_mon.sv
module jitter_fifo_mon #(
    parameter int MAX_DEPTH = 128,
    parameter int WIN_MAX   = 4,
    parameter int STAT_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic              rd_en,
    output logic              rd_bit,
    input  logic [1:0]        depth_sel,
    input  logic              att_en,
    input  logic              peak_mode,
    input  logic              peak_clr,
    input  logic              widen_mode,
    output logic [STAT_W-1:0] occ,
    output logic              widen_req,
    output logic              err
);
    localparam int PW = $clog2(MAX_DEPTH);
    localparam int CW = PW + 1;

    logic [CW-1:0] new_depth, new_half, new_win;
    logic [PW-1:0] new_mask;
    logic [CW-1:0] cur_depth, cur_half, cur_win;
    logic [PW-1:0] cur_mask;
    logic [CW-1:0] lvl_q, lvl_d;
    logic [1:0]    dsel_q;
    logic          head_bit;
    logic          restart;
    logic          near;

    jfm_depth_dec #(.MAX_DEPTH(MAX_DEPTH), .WIN_MAX(WIN_MAX)) u_dec_new (
        .sel(depth_sel), .depth(new_depth), .half(new_half),
        .win(new_win), .mask(new_mask)
    );

    jfm_depth_dec #(.MAX_DEPTH(MAX_DEPTH), .WIN_MAX(WIN_MAX)) u_dec_cur (
        .sel(dsel_q), .depth(cur_depth), .half(cur_half),
        .win(cur_win), .mask(cur_mask)
    );

    assign restart = !att_en || (depth_sel != dsel_q);

    jfm_store #(.MAX_DEPTH(MAX_DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .restart(restart), .sel(depth_sel),
        .depth(new_depth), .half(new_half), .mask(new_mask),
        .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
        .head_bit(head_bit), .lvl_q(lvl_q), .lvl_d(lvl_d),
        .dsel_q(dsel_q), .err_q(err)
    );

    jfm_status #(.CW(CW), .SW(STAT_W), .RST_LV(MAX_DEPTH / 2)) u_status (
        .clk(clk), .rst_n(rst_n), .restart(restart), .peak_mode(peak_mode),
        .peak_clr(peak_clr), .lvl_d(lvl_d), .occ_q(occ)
    );

    assign near      = (lvl_q <= cur_win) || ((cur_depth - lvl_q) <= cur_win);
    assign widen_req = widen_mode && att_en && near;
    assign rd_bit    = att_en ? head_bit : wr_bit;

endmodule

// File: rtl/jitter_fifo_mon_chk.sv
module jitter_fifo_mon_chk #(
    parameter int MAX_DEPTH = 128,
    parameter int STAT_W    = 7,
    localparam int CW = $clog2(MAX_DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              att_en,
    input logic              peak_mode,
    input logic              peak_clr,
    input logic [1:0]        depth_sel,
    input logic [STAT_W-1:0] occ,
    input logic              err,
    input logic [CW-1:0]     lvl_q,
    input logic [1:0]        dsel_q
);
    function automatic logic [CW-1:0] depth_of(input logic [1:0] s);
        return (s == 2'b00) ? CW'(MAX_DEPTH) :
               (s == 2'b01) ? CW'(MAX_DEPTH / 2) : CW'(MAX_DEPTH / 4);
    endfunction

    function automatic logic [STAT_W-1:0] sat(input logic [CW-1:0] v);
        return (v > CW'((1 << STAT_W) - 1)) ? '1 : STAT_W'(v);
    endfunction

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= depth_of(dsel_q));

    p_live_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!peak_mode || peak_clr) |=> (occ == sat(lvl_q)));

    p_peak_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (att_en && peak_mode && !peak_clr && depth_sel == dsel_q) |=> (occ >= $past(occ)));

    p_restart_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !att_en |=> (lvl_q == (depth_of($past(depth_sel)) >> 1)));

endmodule

bind jitter_fifo_mon jitter_fifo_mon_chk #(.MAX_DEPTH(MAX_DEPTH), .STAT_W(STAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .att_en(att_en), .peak_mode(peak_mode),
    .peak_clr(peak_clr), .depth_sel(depth_sel), .occ(occ), .err(err),
    .lvl_q(lvl_q), .dsel_q(dsel_q)
);

// File: tb/jitter_fifo_mon_test.sv
module jitter_fifo_mon_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, wr_bit = 0, rd_en = 0;
    logic       rd_bit;
    logic [1:0] depth_sel = 2'b00;
    logic       att_en = 1, peak_mode = 0, peak_clr = 0, widen_mode = 0;
    logic [6:0] occ;
    logic       widen_req, err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bit         mq[$];
    logic [1:0] m_dsel;
    int         m_occ;
    bit         m_err;

    always #5 clk = ~clk;

    jitter_fifo_mon uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit), .rd_en(rd_en),
        .rd_bit(rd_bit), .depth_sel(depth_sel), .att_en(att_en), .peak_mode(peak_mode),
        .peak_clr(peak_clr), .widen_mode(widen_mode), .occ(occ),
        .widen_req(widen_req), .err(err)
    );

    function automatic int dep(input logic [1:0] s);
        return (s == 2'b00) ? 128 : (s == 2'b01) ? 64 : 32;
    endfunction

    function automatic int win(input logic [1:0] s);
        return (s == 2'b00) ? 4 : (s == 2'b01) ? 3 : 2;
    endfunction

    function automatic int sat(input int v);
        return (v > 127) ? 127 : v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_restart(input logic [1:0] s);
        m_dsel = s;
        mq.delete();
        for (int i = 0; i < dep(s) / 2; i++) mq.push_back(1'b0);
        m_occ = dep(s) / 2;
    endtask

    task automatic model_step();
        bit rd_ok, wr_ok;
        int n;
        if (!att_en || depth_sel != m_dsel) begin
            model_restart(depth_sel);
        end else begin
            rd_ok = rd_en && mq.size() > 0;
            wr_ok = wr_en && (mq.size() < dep(m_dsel) || rd_ok);
            if ((wr_en && !wr_ok) || (rd_en && !rd_ok)) m_err = 1;
            if (rd_ok) void'(mq.pop_front());
            if (wr_ok) mq.push_back(wr_bit);
            n = sat(mq.size());
            if (peak_mode && !peak_clr) m_occ = (n > m_occ) ? n : m_occ;
            else m_occ = n;
        end
    endtask

    task automatic check_outputs();
        int  sz = mq.size();
        bit  nr;
        check(occ == 7'(m_occ), (sz >= 128) ? "R5" : (peak_mode ? "R4" : "R3"), occ, m_occ);
        check(err == m_err, "R9", err, m_err);
        nr = (sz <= win(m_dsel)) || (dep(m_dsel) - sz <= win(m_dsel));
        check(widen_req == (widen_mode && att_en && nr), "R7", widen_req, widen_mode && att_en && nr);
        if (!att_en) check(rd_bit == wr_bit, "R8", rd_bit, wr_bit);
        else if (sz > 0) check(rd_bit == mq[0], "R2", rd_bit, mq[0]);
    endtask

    task automatic cyc(input bit we, input bit wb, input bit re, input logic [1:0] s,
                       input bit pk, input bit wd, input bit en, input bit clr);
        @(negedge clk);
        wr_en = we; wr_bit = wb; rd_en = re; depth_sel = s;
        peak_mode = pk; widen_mode = wd; att_en = en; peak_clr = clr;
        #2;
        check_outputs();
        @(posedge clk);
        model_step();
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr_en = 0; rd_en = 0; depth_sel = 2'b00; att_en = 1;
        peak_mode = 0; peak_clr = 0; widen_mode = 0;
        repeat (3) @(negedge clk);
        model_restart(2'b00);
        m_err = 0;
        rst_n = 1;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();
        // R10: reset state
        check(occ == 7'd64, "R10", occ, 64);
        check(err == 1'b0, "R10", err, 0);
        check(widen_req == 1'b0, "R10", widen_req, 0);

        // R1: depth changes restart at half depth
        cyc(0, 0, 0, 2'b01, 0, 1, 1, 0);
        check(occ == 7'd32, "R1", occ, 32);
        cyc(0, 0, 0, 2'b10, 0, 1, 1, 0);
        check(occ == 7'd16, "R1", occ, 16);
        cyc(0, 0, 0, 2'b11, 0, 1, 1, 0);
        check(occ == 7'd16, "R1", occ, 16);

        // R2/R7/R9: fill depth 32 with a pattern, then overflow
        for (int i = 0; i < 18; i++) cyc(1, i[0] ^ i[2], 0, 2'b11, 0, 1, 1, 0);
        check(occ == 7'd32, "R9", occ, 32);
        check(err == 1'b1, "R9", err, 1);
        // drain completely, then underflow (sticky already set)
        for (int i = 0; i < 34; i++) cyc(0, 0, 1, 2'b11, 0, 1, 1, 0);
        check(occ == 7'd0, "R9", occ, 0);

        // R9: underflow alone after a fresh reset
        do_reset();
        for (int i = 0; i < 66; i++) cyc(0, 0, 1, 2'b00, 0, 1, 1, 0);
        check(err == 1'b1, "R9", err, 1);
        check(occ == 7'd0, "R9", occ, 0);

        // R8: bypass
        do_reset();
        for (int i = 0; i < 8; i++) cyc(1, i[0], 1, 2'b00, 0, 1, 0, 0);
        check(occ == 7'd64, "R8", occ, 64);

        // R5: fill depth 128 fully
        for (int i = 0; i < 64; i++) cyc(1, i[1], 0, 2'b00, 0, 0, 1, 0);
        check(occ == 7'd127, "R5", occ, 127);

        // R4: peak hold while draining
        for (int i = 0; i < 10; i++) cyc(0, 0, 1, 2'b00, 1, 0, 1, 0);
        check(occ == 7'd127, "R4", occ, 127);
        // R6: clear loads current level
        cyc(0, 0, 0, 2'b00, 1, 0, 1, 1);
        check(occ == 7'(mq.size()), "R6", occ, mq.size());
        check(occ == 7'd118, "R6", occ, 118);

        // random phases
        do_reset();
        for (int ph = 0; ph < 30; ph++) begin
            logic [1:0] s  = 2'($urandom_range(0, 3));
            int         pw = $urandom_range(20, 80);
            bit         pk = 1'($urandom_range(0, 1));
            bit         wd = 1'($urandom_range(0, 1));
            for (int i = 0; i < 150; i++) begin
                cyc(($urandom % 100) < pw, 1'($urandom % 2), ($urandom % 100) < 50, s, pk, wd,
                    ($urandom % 50) != 0, ($urandom % 40) == 0);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule